// File: doc/BRIEF.md
# Power-On Strap Capture Sequencer

This block manages a group of five dual-purpose pins that serve as configuration inputs while the chip powers up and as clock outputs from then on. Once the supply-good input goes high, every pin driver is kept in high impedance for a fixed sampling window, so that the external strap resistors alone set the pin levels. When the window closes, the synchronized pin levels are written into a configuration register. In the same clock cycle the output drivers are switched on and a done flag rises.

Four of the captured bits form a frequency-select code. The block decodes this code into a mode index and a spread-spectrum setting. The fifth bit is passed through unchanged as an output-frequency select. Once captured, the configuration can be cleared only by dropping the supply-good input. Raising supply-good again starts a fresh window and a fresh capture. The window length is given in reference-clock cycles by a parameter.

Top module: `strap_capture`

## Requirements
- R1: While reset is high, and at the first negedge after reset is released with supply_ok low, pin_oe is 0, done is 0 and cfg_bits is 0.
- R2: pin_oe is all zeros while supply_ok is low and for the whole sampling window.
- R3: The first clock edge that samples supply_ok high is edge 0. done rises on edge WIN_CYCLES and not before.
- R4: Each pin_in[i] passes through a two-flop synchronizer. If a pin is held steady for the last three cycles of the window, cfg_bits[i] captures its level: a low strap gives 0 and a high strap gives 1.
- R5: On the capture edge, done and all five pin_oe bits go high together.
- R6: After done is set, changes on pin_in have no effect on cfg_bits, mode_idx or spread.
- R7: On the first edge that samples supply_ok low, done, pin_oe and cfg_bits are cleared. A later rise of supply_ok starts a full new window and captures the pins again.
- R8: If supply_ok drops during the window, the window restarts. The next rise of supply_ok again needs WIN_CYCLES edges before done rises.
- R9: The spread output is a function of code = cfg_bits[3:0], with bit 3 as the most significant bit. The encoding is 2'b00 for no spread, 2'b10 for 0.5% and 2'b01 for 0.25%. Codes 1111 and 1110 give 00. Codes 1101 to 1010 give 10. Codes 1001 and 1000 give 01. Every code with bit 3 = 0 gives 00.
- R10: mode_idx equals 15 minus code, so code 1111 gives index 0 and code 0000 gives index 15.
- R11: cfg_bits[4] is the captured level of pin 4. It does not affect spread or mode_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply-good indication; low clears the capture |
| pin_in | input | 5 | Levels sensed on the dual-purpose pins |
| pin_oe | output | 5 | Output-driver enables, one per pin |
| cfg_bits | output | 5 | Captured strap configuration |
| done | output | 1 | Capture complete, drivers enabled |
| mode_idx | output | 4 | Decoded frequency mode index |
| spread | output | 2 | Decoded spread setting |

## Verification
A wrong window counter shows at the ports as done and pin_oe rising one or more cycles away from edge WIN_CYCLES, so each power-up is checked on both the cycle before the expected rise and the cycle of the rise. A missing or doubled synchronizer stage shows as a pin change near the end of the window being captured, or being missed. A capture register that keeps loading after done shows on cfg_bits within three cycles of a late pin change. A stale phase after a supply drop shows on the very next window, which then closes early.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int PIN_COUNT = 5;
    localparam int CODE_W    = 4;

    typedef enum logic [1:0] {
        PH_OFF    = 2'b00,
        PH_WINDOW = 2'b01,
        PH_RUN    = 2'b10
    } phase_t;

    typedef enum logic [1:0] {
        SPR_NONE = 2'b00,
        SPR_QTR  = 2'b01,
        SPR_HALF = 2'b10
    } spread_t;

    // Spread setting for a frequency-select code
    function automatic spread_t spread_of(input logic [CODE_W-1:0] code);
        spread_t s;
        if (!code[3])
            s = SPR_NONE;
        else if (code[2:1] == 2'b11)
            s = SPR_NONE;
        else if (code[2:1] == 2'b00)
            s = SPR_QTR;
        else
            s = SPR_HALF;
        return s;
    endfunction

    // Mode index counts down from the all-ones code
    function automatic logic [CODE_W-1:0] mode_of(input logic [CODE_W-1:0] code);
        return ~code;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta, stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b0;
                stable <= 1'b0;
            end else begin
                meta   <= d[i];
                stable <= meta;
            end
        end
        assign q[i] = stable;
    end
endmodule

// File: rtl/strap_window_seq.sv
module strap_window_seq
    import strap_pkg::*;
#(
    parameter int WIN_CYCLES = 100000,
    parameter int WIDTH      = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_ok,
    input  logic [WIDTH-1:0] pins_sync,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] cfg,
    output logic             done
);
    localparam int CNT_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_CYCLES - 1);

    phase_t           phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !supply_ok) begin
            phase <= PH_OFF;
            cnt   <= '0;
            oe    <= '0;
            cfg   <= '0;
            done  <= 1'b0;
        end else begin
            unique case (phase)
                PH_OFF: begin
                    phase <= PH_WINDOW;
                    cnt   <= '0;
                end
                PH_WINDOW: begin
                    if (cnt == LAST) begin
                        cfg   <= pins_sync;
                        oe    <= '1;
                        done  <= 1'b1;
                        phase <= PH_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RUN: ;
                default: phase <= PH_OFF;
            endcase
        end
    end

    AST_WINDOW_HIZ: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN) |-> (oe == '0)) else $error("drivers on before capture"); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt <= LAST)) else $error("window counter overrun"); // R3

    AST_DONE_WITH_OE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (&oe)) else $error("done without drivers"); // R5

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done)) |-> $stable(cfg)) else $error("capture changed after done"); // R6

    AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (!done && oe == '0 && cfg == '0)) else $error("supply drop not honoured"); // R7
endmodule

// File: rtl/strap_decode.sv
module strap_decode
    import strap_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] mode_idx,
    output logic [1:0]        spread
);
    always_comb begin
        mode_idx = mode_of(code);
        spread   = spread_of(code);
        AST_SPREAD_LEGAL: assert (spread != 2'b11) else $error("illegal spread"); // R9
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
#(
    parameter int WIN_CYCLES = 100000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 supply_ok,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic [PIN_COUNT-1:0] cfg_bits,
    output logic                 done,
    output logic [CODE_W-1:0]    mode_idx,
    output logic [1:0]           spread
);
    logic [PIN_COUNT-1:0] pins_sync;

    strap_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    strap_window_seq #(.WIN_CYCLES(WIN_CYCLES), .WIDTH(PIN_COUNT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .supply_ok (supply_ok),
        .pins_sync (pins_sync),
        .oe        (pin_oe),
        .cfg       (cfg_bits),
        .done      (done)
    );

    // The fifth pin (R11) is outside the frequency-select code
    strap_decode u_dec (
        .code     (cfg_bits[CODE_W-1:0]),
        .mode_idx (mode_idx),
        .spread   (spread)
    );
endmodule

// File: tb/strap_capture_test.sv
module strap_capture_test;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b0;
    logic [4:0] pin_in = '0;
    logic [4:0] pin_oe, cfg_bits;
    logic       done;
    logic [3:0] mode_idx;
    logic [1:0] spread;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    strap_capture #(.WIN_CYCLES(W)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .pin_in(pin_in),
        .pin_oe(pin_oe), .cfg_bits(cfg_bits), .done(done),
        .mode_idx(mode_idx), .spread(spread)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_spread(input logic [3:0] c);
        if (c inside {4'b1101, 4'b1100, 4'b1011, 4'b1010}) return 2'b10;
        if (c inside {4'b1001, 4'b1000}) return 2'b01;
        return 2'b00;
    endfunction

    // Power-up with pins steady; checks window timing, capture and decode
    task automatic power_up(input logic [4:0] pins);
        @(negedge clk);
        pin_in = pins;
        supply_ok = 1'b1;
        repeat (W) begin
            @(negedge clk);
            if (pin_oe != 0) break;
        end
        check(pin_oe == 0 && done == 0, "R2 window hi-z", pin_oe, 0);
        check(done == 0, "R3 done early", done, 0);
        @(negedge clk);
        check(done == 1, "R3 done at window end", done, 1);
        check(pin_oe == 5'h1f, "R5 drivers enabled with done", pin_oe, 5'h1f);
        check(cfg_bits == pins, "R4 captured pins", cfg_bits, pins);
        check(mode_idx == 4'd15 - pins[3:0], "R10 mode index", mode_idx, 4'd15 - pins[3:0]);
        check(spread == exp_spread(pins[3:0]), "R9 spread", spread, exp_spread(pins[3:0]));
    endtask

    task automatic power_down;
        @(negedge clk);
        supply_ok = 1'b0;
        @(negedge clk);
        check(done == 0 && pin_oe == 0 && cfg_bits == 0, "R7 cleared on drop",
              {done, pin_oe, cfg_bits}, 0);
    endtask

    task automatic test_reset;
        repeat (3) @(negedge clk);
        check(pin_oe == 0 && done == 0 && cfg_bits == 0, "R1 reset state",
              {done, pin_oe, cfg_bits}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(pin_oe == 0 && done == 0 && cfg_bits == 0, "R1 after release",
              {done, pin_oe, cfg_bits}, 0);
    endtask

    task automatic test_all_codes;
        for (int c = 0; c < 16; c++) begin
            power_up({c[0], c[3:0]});
            power_down();
        end
    endtask

    task automatic test_ignore_after_done;
        power_up(5'b01101);
        @(negedge clk);
        pin_in = 5'b10010;
        repeat (5) @(negedge clk);
        check(cfg_bits == 5'b01101, "R6 cfg frozen", cfg_bits, 5'b01101);
        check(spread == 2'b10 && mode_idx == 4'd2, "R6 decode frozen", {mode_idx, spread}, {4'd2, 2'b10});
        power_down();
    endtask

    task automatic test_midwindow_drop;
        @(negedge clk);
        supply_ok = 1'b1;
        repeat (W - 4) @(negedge clk);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 0, "R8 no done after early drop", done, 0);
        power_up(5'b11000);
        power_down();
    endtask

    task automatic test_late_pin_change;
        @(negedge clk);
        pin_in = 5'b00000;
        supply_ok = 1'b1;
        repeat (W - 4) @(negedge clk);
        pin_in = 5'b11001;
        repeat (5) @(negedge clk);
        check(done == 1, "R3 done in late-change run", done, 1);
        check(cfg_bits == 5'b11001, "R4 last steady level captured", cfg_bits, 5'b11001);
        check(cfg_bits[4] == 1 && spread == 2'b01 && mode_idx == 4'd6,
              "R11 fifth pin independent of decode", {cfg_bits[4], mode_idx, spread}, {1'b1, 4'd6, 2'b01});
        power_down();
        power_up(5'b00111);
        check(cfg_bits == 5'b00111, "R7 re-capture after new supply rise", cfg_bits, 5'b00111);
        power_down();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        test_reset();
        test_all_codes();
        test_ignore_after_done();
        test_midwindow_drop();
        test_late_pin_change();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule